// File: doc/BRIEF.md
# Buffered Interrupt Status Controller

This block sits between a USB device engine and an external host processor. It collects six kinds of event and masks each one against a programmable enable register. It signals the processor through a single active-low interrupt line. Each time the line is low, one read strobe returns one byte on the data output. That byte is either a status word with exactly one bit set, or the data the processor asked for in a register read. An event that is enabled becomes pending. Pending events are kept and shown one at a time, from the highest status bit down. The strobe that reads a status byte clears the event it showed.

The processor can start a register read. From then on, no new status interrupt is raised until the requested data has been handed over. The next interrupt after that point therefore means the data has arrived. A status interrupt that was already showing when the read began is still returned first. The ready output separates the two cases: it is high only while the interrupt stands for requested data. The flags event is not a pulse input. The block derives it by watching the empty state of every OUT FIFO for changes.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the interrupt output is high and ready is low. Whenever the interrupt output is high, the data output is 0x00 and ready is low.
- R2: A status byte has exactly one bit set. The bit positions are: setup 0x80, endpoint-0 buffer 0x40, flags 0x20, enumeration done 0x04, bus activity 0x02, ready event 0x01. Bits 4 and 3 are never set.
- R3: The enable register uses the same bit positions as the status byte. An event whose enable bit is 0 at its arrival is dropped. It is not shown later, even if its enable bit is set afterwards.
- R4: An enabled event pulse drives the interrupt output low two clock edges after it is sampled. The status byte stays on the data output and ready stays low until a strobe.
- R5: A strobe while a status byte is shown clears that event. The interrupt output then goes high for at least one cycle before any further interrupt.
- R6: When several events are pending, they are shown in order from the highest status bit to the lowest.
- R7: An event that repeats while the same event is already pending merges with it and is shown only once.
- R8: The flags event fires on every change of any OUT FIFO's empty input, in either direction.
- R9: After a register read request, no new status byte is shown until the requested data has been read by a strobe. Events that arrive in the meantime stay pending and are shown afterwards.
- R10: When requested data is valid and no status byte is shown, the interrupt output goes low with ready high and the data on the output. A strobe ends the read.
- R11: If a status byte is already shown when a read request starts, it is returned first with ready low. The requested data follows as the next interrupt.
- R12: A strobe while nothing is shown has no effect. If an event arrives in the same cycle as the strobe that clears that same event, it becomes pending again and is shown again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_setup_i | input | 1 | Setup packet event pulse |
| evt_ep0_i | input | 1 | Endpoint-0 buffer available event pulse |
| evt_enum_i | input | 1 | Enumeration complete event pulse |
| evt_bus_i | input | 1 | Bus activity change event pulse |
| evt_rdy_i | input | 1 | Device ready event pulse |
| fifo_empty_i | input | NUM_OUT_FIFOS | Empty state of each OUT FIFO (1 = empty) |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 8 | Enable register write value |
| rd_req_i | input | 1 | Pulse: the processor started a register read |
| rd_vld_i | input | 1 | Pulse: requested register data is valid |
| rd_data_i | input | 8 | Requested register data |
| strobe_i | input | 1 | Read strobe from the processor, one cycle per read |
| data_o | output | 8 | Low data byte: status byte or requested data |
| irq_n_o | output | 1 | Active-low interrupt |
| ready_o | output | 1 | High when the interrupt stands for requested data |

## Verification
Two situations can land in the same cycle. In the first, the strobe that clears a shown event meets a new pulse of that same event. The bench drives both together and expects the byte to be shown a second time. In the second, a status byte is already shown when a register read starts and its data arrives. The bench expects the status byte with ready low, and then the data with ready high. Each is judged against a scoreboard queue of expected bytes and ready values, which is drained strobe by strobe.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int ST_W = 8;
  localparam int B_SETUP = 7;
  localparam int B_EP0   = 6;
  localparam int B_FLAGS = 5;
  localparam int B_ENUM  = 2;
  localparam int B_BUS   = 1;
  localparam int B_RDY   = 0;
  localparam logic [ST_W-1:0] VALID_MASK = 8'hE7;

  typedef logic [ST_W-1:0] st_vec_t;
endpackage

// File: rtl/irq_evt_capture.sv
module irq_evt_capture
  import irq_status_pkg::*;
#(
  parameter int NUM_OUT_FIFOS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_setup_i,
  input  logic                     evt_ep0_i,
  input  logic                     evt_enum_i,
  input  logic                     evt_bus_i,
  input  logic                     evt_rdy_i,
  input  logic [NUM_OUT_FIFOS-1:0] fifo_empty_i,
  input  st_vec_t                  en_i,
  output st_vec_t                  set_o
);
  logic [NUM_OUT_FIFOS-1:0] empty_prev_q;
  logic [NUM_OUT_FIFOS-1:0] empty_chg;
  logic                     flags_evt;
  st_vec_t                  raw;

  // One change detector per OUT FIFO
  for (genvar g = 0; g < NUM_OUT_FIFOS; g++) begin : g_edge
    assign empty_chg[g] = fifo_empty_i[g] ^ empty_prev_q[g];
  end

  assign flags_evt = |empty_chg;

  always_comb begin
    raw          = '0;
    raw[B_SETUP] = evt_setup_i;
    raw[B_EP0]   = evt_ep0_i;
    raw[B_FLAGS] = flags_evt;
    raw[B_ENUM]  = evt_enum_i;
    raw[B_BUS]   = evt_bus_i;
    raw[B_RDY]   = evt_rdy_i;
  end

  assign set_o = raw & en_i & VALID_MASK;

  // FIFOs are taken as empty out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_prev_q <= '1;
    else        empty_prev_q <= fifo_empty_i;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_status_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  st_vec_t set_i,
  input  st_vec_t clr_i,
  output st_vec_t pend_o
);
  st_vec_t pend_q;
  st_vec_t pend_d;

  // A set in the same cycle as a clear wins
  for (genvar b = 0; b < ST_W; b++) begin : g_bit
    if (VALID_MASK[b]) begin : g_live
      assign pend_d[b] = set_i[b] | (pend_q[b] & ~clr_i[b]);
    end else begin : g_tied
      assign pend_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_status_pkg::*;
(
  input  st_vec_t req_i,
  output st_vec_t grant_o,
  output logic    any_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = ST_W - 1; i >= 0; i--) begin
      grant_o[i] = req_i[i] & ~found;
      found      = found | req_i[i];
    end
    any_o = found;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int            NUM_OUT_FIFOS = 2,
  parameter logic [7:0]    EN_RESET      = 8'h00
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_setup_i,
  input  logic                     evt_ep0_i,
  input  logic                     evt_enum_i,
  input  logic                     evt_bus_i,
  input  logic                     evt_rdy_i,
  input  logic [NUM_OUT_FIFOS-1:0] fifo_empty_i,
  input  logic                     en_we_i,
  input  logic [7:0]               en_wdata_i,
  input  logic                     rd_req_i,
  input  logic                     rd_vld_i,
  input  logic [7:0]               rd_data_i,
  input  logic                     strobe_i,
  output logic [7:0]               data_o,
  output logic                     irq_n_o,
  output logic                     ready_o
);
  // Reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // State
  st_vec_t en_q, en_d;
  st_vec_t sel_q, sel_d;
  logic    show_stat_q, show_stat_d;
  logic    show_data_q, show_data_d;
  logic    rd_busy_q, rd_busy_d;
  logic    data_ok_q, data_ok_d;
  logic [7:0] data_q, data_d;

  st_vec_t set_vec, clr_vec, pend, grant;
  logic    pend_any, busy_now, idle, cap_data;

  irq_evt_capture #(.NUM_OUT_FIFOS(NUM_OUT_FIFOS)) u_cap (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .evt_setup_i  (evt_setup_i),
    .evt_ep0_i    (evt_ep0_i),
    .evt_enum_i   (evt_enum_i),
    .evt_bus_i    (evt_bus_i),
    .evt_rdy_i    (evt_rdy_i),
    .fifo_empty_i (fifo_empty_i),
    .en_i         (en_q),
    .set_o        (set_vec)
  );

  irq_pend_bank u_pend (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  irq_prio_pick u_pick (
    .req_i   (pend),
    .grant_o (grant),
    .any_o   (pend_any)
  );

  assign clr_vec  = (show_stat_q && strobe_i) ? sel_q : '0;
  assign busy_now = rd_busy_q | rd_req_i;
  assign idle     = ~show_stat_q & ~show_data_q;
  assign cap_data = busy_now & rd_vld_i & ~data_ok_q;

  // Next-state logic
  always_comb begin
    en_d        = en_we_i ? (en_wdata_i & VALID_MASK) : en_q;
    sel_d       = sel_q;
    show_stat_d = show_stat_q;
    show_data_d = show_data_q;
    rd_busy_d   = rd_busy_q | rd_req_i;
    data_ok_d   = data_ok_q | cap_data;
    data_d      = cap_data ? rd_data_i : data_q;

    if (show_stat_q && strobe_i) begin
      show_stat_d = 1'b0;
    end else if (show_data_q && strobe_i) begin
      show_data_d = 1'b0;
      rd_busy_d   = 1'b0;
      data_ok_d   = 1'b0;
    end else if (idle) begin
      if (busy_now) begin
        if (data_ok_q) show_data_d = 1'b1;
      end else if (pend_any) begin
        show_stat_d = 1'b1;
        sel_d       = grant;
      end
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q        <= EN_RESET & VALID_MASK;
      sel_q       <= '0;
      show_stat_q <= 1'b0;
      show_data_q <= 1'b0;
      rd_busy_q   <= 1'b0;
      data_ok_q   <= 1'b0;
      data_q      <= '0;
    end else begin
      en_q        <= en_d;
      sel_q       <= sel_d;
      show_stat_q <= show_stat_d;
      show_data_q <= show_data_d;
      rd_busy_q   <= rd_busy_d;
      data_ok_q   <= data_ok_d;
      data_q      <= data_d;
    end
  end

  assign data_o  = show_stat_q ? sel_q : (show_data_q ? data_q : 8'h00);
  assign irq_n_o = ~(show_stat_q | show_data_q);
  assign ready_o = show_data_q;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe_i,
  input logic [7:0] data_o,
  input logic       irq_n_o,
  input logic       ready_o,
  input logic       rd_busy
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o |-> (data_o == 8'h00 && !ready_o));

  p_status_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !ready_o) |-> ($countones(data_o) == 1 && data_o[4:3] == 2'b00));

  p_hold_shown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !strobe_i) |=> (!irq_n_o && $stable(data_o) && $stable(ready_o)));

  p_gap_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && strobe_i) |=> irq_n_o);

  p_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && irq_n_o) |=> (irq_n_o || ready_o));

  p_ready_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !irq_n_o);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe_i (strobe_i),
  .data_o   (data_o),
  .irq_n_o  (irq_n_o),
  .ready_o  (ready_o),
  .rd_busy  (rd_busy_q)
);

// File: tb/irq_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb_top;
  localparam int NF = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic evt_setup, evt_ep0, evt_enum, evt_bus, evt_rdy;
  logic [NF-1:0] fifo_empty;
  logic en_we, rd_req, rd_vld, strobe;
  logic [7:0] en_wdata, rd_data;
  logic [7:0] data_o;
  logic irq_n, ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [8:0] sb_q[$];

  always #2.5 clk = ~clk;

  irq_status_ctrl #(.NUM_OUT_FIFOS(NF)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .evt_setup_i(evt_setup), .evt_ep0_i(evt_ep0), .evt_enum_i(evt_enum),
    .evt_bus_i(evt_bus), .evt_rdy_i(evt_rdy), .fifo_empty_i(fifo_empty),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .rd_req_i(rd_req),
    .rd_vld_i(rd_vld), .rd_data_i(rd_data), .strobe_i(strobe),
    .data_o(data_o), .irq_n_o(irq_n), .ready_o(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ev bits: [0] setup [1] ep0 [2] enum [3] bus [4] ready event
  task automatic pulse(input logic [4:0] ev);
    @(negedge clk);
    {evt_rdy, evt_bus, evt_enum, evt_ep0, evt_setup} = ev;
    @(negedge clk);
    {evt_rdy, evt_bus, evt_enum, evt_ep0, evt_setup} = '0;
  endtask

  task automatic write_en(input logic [7:0] v);
    @(negedge clk);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic expect_item(input logic rdy, input logic [7:0] d);
    sb_q.push_back({rdy, d});
  endtask

  // Monitor side: wait for an interrupt, compare with the queue head, strobe
  task automatic pop_one(input string req);
    logic [8:0] exp;
    int n;
    exp = sb_q.pop_front();
    n = 0;
    while (irq_n !== 1'b0 && n < 60) begin
      @(negedge clk);
      n++;
    end
    check(irq_n === 1'b0, req, irq_n, 0);
    check({ready, data_o} === exp, req, {ready, data_o}, exp);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    check(irq_n === 1'b1, {req, " gap"}, irq_n, 1);
  endtask

  task automatic drain(input string req);
    while (sb_q.size() > 0) pop_one(req);
  endtask

  task automatic quiet(input int cyc, input string req);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (irq_n !== 1'b1 || data_o !== 8'h00 || ready !== 1'b0) ok = 1'b0;
    end
    check(ok, req, {irq_n, ready, data_o}, 10'h200);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {evt_rdy, evt_bus, evt_enum, evt_ep0, evt_setup} = '0;
    fifo_empty = '1;
    en_we = 1'b0; en_wdata = '0; rd_req = 1'b0; rd_vld = 1'b0;
    rd_data = '0; strobe = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(irq_n === 1'b1 && ready === 1'b0 && data_o === 8'h00, "R1",
          {irq_n, ready, data_o}, 10'h200);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet(3, "R1");

    write_en(8'hFF);

    // R2/R4/R5: each source alone, expected bit position
    pulse(5'b00001); expect_item(0, 8'h80); drain("R2 setup");
    pulse(5'b00010); expect_item(0, 8'h40); drain("R2 ep0");
    pulse(5'b00100); expect_item(0, 8'h04); drain("R2 enum");
    pulse(5'b01000); expect_item(0, 8'h02); drain("R2 bus");
    pulse(5'b10000); expect_item(0, 8'h01); drain("R2 rdy");

    // R4: byte held while no strobe
    pulse(5'b00100);
    repeat (6) @(negedge clk);
    check(irq_n === 1'b0 && data_o === 8'h04 && ready === 1'b0, "R4",
          {irq_n, ready, data_o}, 10'h004);
    expect_item(0, 8'h04); drain("R4");

    // R6: several at once, shown highest bit first
    pulse(5'b11011);
    expect_item(0, 8'h80); expect_item(0, 8'h40);
    expect_item(0, 8'h02); expect_item(0, 8'h01);
    drain("R6");
    quiet(5, "R6");

    // R7: repeat while pending merges
    pulse(5'b00001);
    pulse(5'b00001);
    pulse(5'b00001);
    expect_item(0, 8'h80); drain("R7");
    quiet(6, "R7");

    // R3: disabled event dropped, not shown after enabling
    write_en(8'hE6);
    pulse(5'b10000);
    quiet(6, "R3 disabled");
    write_en(8'hE7);
    quiet(6, "R3 late enable");

    // R8: flags on each empty change, both directions, any FIFO
    @(negedge clk); fifo_empty[0] = 1'b0;
    expect_item(0, 8'h20); drain("R8 fifo0 fill");
    @(negedge clk); fifo_empty[1] = 1'b0;
    expect_item(0, 8'h20); drain("R8 fifo1 fill");
    @(negedge clk); fifo_empty[0] = 1'b1;
    expect_item(0, 8'h20); drain("R8 fifo0 empty");
    quiet(4, "R8 steady");

    // R9/R10: read request holds off new status
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    pulse(5'b00001);
    quiet(6, "R9 holdoff");
    @(negedge clk); rd_vld = 1'b1; rd_data = 8'h5A;
    @(negedge clk); rd_vld = 1'b0; rd_data = 8'h00;
    expect_item(1, 8'h5A); expect_item(0, 8'h80);
    drain("R10 data then status R9");

    // R11: status already shown when the read starts
    pulse(5'b01000);
    repeat (3) @(negedge clk);
    check(irq_n === 1'b0, "R11 pre", irq_n, 0);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; rd_vld = 1'b1; rd_data = 8'hC3;
    @(negedge clk); rd_vld = 1'b0;
    expect_item(0, 8'h02); expect_item(1, 8'hC3);
    drain("R11");

    // R12: idle strobe has no effect
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    quiet(3, "R12 idle strobe");

    // R12: new event in the same cycle as the clearing strobe
    pulse(5'b00001);
    repeat (3) @(negedge clk);
    check(irq_n === 1'b0 && data_o === 8'h80, "R12 shown",
          {irq_n, data_o}, 9'h080);
    strobe = 1'b1; evt_setup = 1'b1;
    @(negedge clk);
    strobe = 1'b0; evt_setup = 1'b0;
    expect_item(0, 8'h80); drain("R12 re-pend");
    quiet(5, "R12 after");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule